// File: doc/BRIEF.md
# Independent Watchdog Timer

This block is a watchdog down-counter that runs from its own low-speed clock, so it keeps counting whether or not the bus clock is running. Software controls it only through writes of 32-bit key values to a command register. One key starts the counter. Another key reloads it. A third key opens the divider and reload registers for writing. Once the counter has started, no write of any kind stops it; only the system reset returns it to idle.

When the count runs out, the block raises a reset request and holds it for a fixed number of watchdog-clock cycles. In the same cycle it sets a cause flag. The system reset does not clear this flag; only the power-on reset does, or an explicit write from software. Boot code can therefore tell a watchdog reset from an ordinary one. A debug input stalls the divider and the counter while the processor sits at a breakpoint.

Each command is carried from the bus clock into the watchdog clock by flipping a toggle, which is then synchronised on the other side. For divider and reload updates the toggle is echoed back to the bus side. While that echo is outstanding, a busy bit stays set.

Top module: `indep_watchdog`

## Requirements
- R1: After reset the block is idle and locked. There is no reset request, the cause flag is 0 and the status word reads 0. The divider code reads 0 and the reload value reads all ones.
- R2: A write of 0x0000CCCC to the command register (address 0) starts the counter. Status bit 2 (running) then reads 1.
- R3: The reset request rises exactly reload × divisor watchdog-clock cycles after a start or reload command takes effect. Taking effect adds a few cycles of synchronisation delay.
- R4: A write of 0x0000AAAA reloads the counter and pushes back the expiry. While the block is idle, this write does not start it.
- R5: Once the counter is running, no key value and no register write stops it. Only the system reset rst_n returns it to idle.
- R6: A write of 0x00005555 to the command register unlocks the divider register (address 1) and the reload register (address 2). Any other key value locks them again. A write to either register while locked has no effect.
- R7: Divider code c, bits [2:0], selects a divisor of 4 << c for c from 0 to 6. Code 7 also gives 256.
- R8: Status bit 0 (divider update in flight) and status bit 1 (reload update in flight) are set by an accepted write. They clear once the watchdog clock has taken the new value. A configuration write made while either bit is set has no effect.
- R9: While dbg_freeze is high, the divider and the counter hold their values. The expiry is delayed by the number of frozen watchdog-clock cycles.
- R10: Each expiry holds wdg_rst_req high for exactly HOLD_CYC watchdog-clock cycles.
- R11: The cause flag (status bit 3 and the cause_flag output) sets on expiry and survives rst_n. It is cleared by writing 1 to bit 3 of the status register (address 3), or by por_n.
- R12: Counting and expiry carry on while the bus clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low; clears the cause flag and the reset stretcher |
| rst_n | input | 1 | System reset, active low; returns the watchdog to idle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 command, 1 divider, 2 reload, 3 status |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 32 | Read data, combinational |
| lsclk | input | 1 | Independent watchdog clock |
| dbg_freeze | input | 1 | Debug halt, synchronous to lsclk; stalls counting |
| wdg_rst_req | output | 1 | Reset request, stretched to HOLD_CYC cycles |
| cause_flag | output | 1 | Sticky watchdog-reset cause |

## Verification
The bench builds the block with RLD_W = 8, HOLD_CYC = 4 and the other parameters at their defaults. The default reload of 255 × 4 and a 2 × 256 setting with the top divider code then expire within a few hundred to about a thousand watchdog cycles. This keeps the exact expiry cycle, the freeze shift, the expiry with the bus clock stopped and the longest divisor all within a short run. Expiry is checked against a window that covers the synchronisation delay, while the request being low before the window opens is checked on every watchdog cycle.

// File: rtl/indep_watchdog.sv
module indep_watchdog #(
  parameter int PRE_W         = 3,
  parameter int RLD_W         = 12,
  parameter int DIV_BASE_LOG2 = 2,
  parameter int HOLD_CYC      = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic        lsclk,
  input  logic        dbg_freeze,
  output logic        wdg_rst_req,
  output logic        cause_flag
);
  localparam int MAX_SH = (1 << PRE_W) - 2;
  localparam int PC_W   = DIV_BASE_LOG2 + MAX_SH;
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [31:0] KEY_START  = 32'h0000_CCCC;
  localparam logic [31:0] KEY_RELOAD = 32'h0000_AAAA;
  localparam logic [31:0] KEY_OPEN   = 32'h0000_5555;
  localparam logic [1:0] A_KEY = 2'd0, A_PRE = 2'd1, A_RLD = 2'd2, A_STAT = 2'd3;

  // bus clock domain
  logic             unlocked, pre_busy, rld_busy;
  logic             cfg_tgl, start_tgl, rld_tgl, clr_tgl;
  logic [PRE_W-1:0] pre_sh;
  logic [RLD_W-1:0] rld_sh;
  logic [SYNC_STAGES-1:0] ack_ff, run_ff, flag_ff;

  wire busy   = pre_busy | rld_busy;
  wire wr_key = wr_en && wr_addr == A_KEY;
  wire wr_pre = wr_en && wr_addr == A_PRE && unlocked && !busy;
  wire wr_rld = wr_en && wr_addr == A_RLD && unlocked && !busy;
  wire wr_clr = wr_en && wr_addr == A_STAT && wr_data[3];
  wire ack_s  = ack_ff[SYNC_STAGES-1];
  wire run_s  = run_ff[SYNC_STAGES-1];
  wire flag_s = flag_ff[SYNC_STAGES-1];

  // lsclk domain
  logic [SYNC_STAGES:0] start_ff, rld_ff, cfg_ff, clr_ff;
  logic             run_q;
  logic [PRE_W-1:0] pre_q;
  logic [RLD_W-1:0] rld_q, cnt_q;
  logic [PC_W-1:0]  pc_q;
  logic [HOLD_W-1:0] hold_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      unlocked  <= 1'b0;
      pre_busy  <= 1'b0;
      rld_busy  <= 1'b0;
      cfg_tgl   <= 1'b0;
      start_tgl <= 1'b0;
      rld_tgl   <= 1'b0;
      pre_sh    <= '0;
      rld_sh    <= '1;
    end else begin
      if (wr_key) begin
        unlocked <= wr_data == KEY_OPEN;
        if (wr_data == KEY_START)  start_tgl <= ~start_tgl;
        if (wr_data == KEY_RELOAD) rld_tgl   <= ~rld_tgl;
      end
      if (wr_pre) begin
        pre_sh   <= wr_data[PRE_W-1:0];
        pre_busy <= 1'b1;
        cfg_tgl  <= ~cfg_tgl;
      end else if (wr_rld) begin
        rld_sh   <= wr_data[RLD_W-1:0];
        rld_busy <= 1'b1;
        cfg_tgl  <= ~cfg_tgl;
      end else if (busy && ack_s == cfg_tgl) begin
        pre_busy <= 1'b0;
        rld_busy <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_ff <= '0;
      run_ff <= '0;
    end else begin
      ack_ff <= {ack_ff[SYNC_STAGES-2:0], cfg_ff[SYNC_STAGES]};
      run_ff <= {run_ff[SYNC_STAGES-2:0], run_q};
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      clr_tgl <= 1'b0;
      flag_ff <= '0;
    end else begin
      if (wr_clr) clr_tgl <= ~clr_tgl;
      flag_ff <= {flag_ff[SYNC_STAGES-2:0], flag_q};
    end

  always_comb
    case (rd_addr)
      A_PRE:   rd_data = {{(32-PRE_W){1'b0}}, pre_sh};
      A_RLD:   rd_data = {{(32-RLD_W){1'b0}}, rld_sh};
      A_STAT:  rd_data = {28'd0, flag_s, run_s, rld_busy, pre_busy};
      default: rd_data = '0;
    endcase

  // watchdog clock domain
  always_ff @(posedge lsclk or negedge rst_n)
    if (!rst_n) begin
      start_ff <= '0;
      rld_ff   <= '0;
      cfg_ff   <= '0;
    end else begin
      start_ff <= {start_ff[SYNC_STAGES-1:0], start_tgl};
      rld_ff   <= {rld_ff[SYNC_STAGES-1:0], rld_tgl};
      cfg_ff   <= {cfg_ff[SYNC_STAGES-1:0], cfg_tgl};
    end

  always_ff @(posedge lsclk or negedge por_n)
    if (!por_n) clr_ff <= '0;
    else        clr_ff <= {clr_ff[SYNC_STAGES-1:0], clr_tgl};

  wire start_ev = start_ff[SYNC_STAGES] ^ start_ff[SYNC_STAGES-1];
  wire rld_ev   = rld_ff[SYNC_STAGES]   ^ rld_ff[SYNC_STAGES-1];
  wire cfg_ev   = cfg_ff[SYNC_STAGES]   ^ cfg_ff[SYNC_STAGES-1];
  wire clr_ev   = clr_ff[SYNC_STAGES]   ^ clr_ff[SYNC_STAGES-1];
  wire kick_ev  = start_ev | rld_ev;

  wire [PRE_W-1:0] div_sh = (int'(pre_q) > MAX_SH) ? PRE_W'(MAX_SH) : pre_q;
  wire [PC_W-1:0]  div_m1 = PC_W'((1 << (DIV_BASE_LOG2 + int'(div_sh))) - 1);
  wire tick   = pc_q == div_m1;
  wire active = run_q && !dbg_freeze && !kick_ev;
  wire expire = active && tick && cnt_q <= RLD_W'(1);

  always_ff @(posedge lsclk or negedge rst_n)
    if (!rst_n) begin
      run_q <= 1'b0;
      pre_q <= '0;
      rld_q <= '1;
      cnt_q <= '1;
      pc_q  <= '0;
    end else begin
      if (cfg_ev) begin
        pre_q <= pre_sh;
        rld_q <= rld_sh;
      end
      if (start_ev) run_q <= 1'b1;
      if (kick_ev) begin
        cnt_q <= rld_q;
        pc_q  <= '0;
      end else if (active) begin
        if (tick) begin
          pc_q  <= '0;
          cnt_q <= (cnt_q <= RLD_W'(1)) ? rld_q : cnt_q - RLD_W'(1);
        end else begin
          pc_q <= pc_q + PC_W'(1);
        end
      end
    end

  always_ff @(posedge lsclk or negedge por_n)
    if (!por_n) begin
      hold_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (expire)               hold_q <= HOLD_W'(HOLD_CYC);
      else if (hold_q != '0)    hold_q <= hold_q - HOLD_W'(1);
      if (expire)      flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
    end

  assign wdg_rst_req = hold_q != '0;
  assign cause_flag  = flag_q;
endmodule

// File: rtl/indep_watchdog_chk.sv
module indep_watchdog_chk #(
  parameter int PRE_W    = 3,
  parameter int RLD_W    = 12,
  parameter int PC_W     = 8,
  parameter int HOLD_CYC = 4
) (
  input logic             clk,
  input logic             lsclk,
  input logic             por_n,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic             unlocked,
  input logic             pre_busy,
  input logic             rld_busy,
  input logic [PRE_W-1:0] pre_sh,
  input logic [RLD_W-1:0] rld_sh,
  input logic             run_q,
  input logic             kick_ev,
  input logic             dbg_freeze,
  input logic [RLD_W-1:0] cnt_q,
  input logic [PC_W-1:0]  pc_q,
  input logic             wdg_rst_req,
  input logic             cause_flag
);
  int unsigned hcnt;
  always_ff @(posedge lsclk or negedge por_n)
    if (!por_n)           hcnt <= 0;
    else if (wdg_rst_req) hcnt <= hcnt + 1;
    else                  hcnt <= 0;

  p_run_sticky_r5: assert property (@(posedge lsclk) disable iff (!rst_n)
    run_q |=> run_q);

  p_freeze_stall_r9: assert property (@(posedge lsclk) disable iff (!rst_n)
    (dbg_freeze && !kick_ev) |=> ($stable(cnt_q) && $stable(pc_q)));

  p_flag_on_expiry_r11: assert property (@(posedge lsclk) disable iff (!por_n)
    $rose(wdg_rst_req) |-> cause_flag);

  p_hold_len_r10: assert property (@(posedge lsclk) disable iff (!por_n)
    $fell(wdg_rst_req) |-> hcnt == HOLD_CYC);

  p_locked_pre_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && !unlocked) |=> $stable(pre_sh));

  p_busy_rld_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && (pre_busy || rld_busy)) |=> $stable(rld_sh));
endmodule

bind indep_watchdog indep_watchdog_chk #(
  .PRE_W(PRE_W), .RLD_W(RLD_W), .PC_W(PC_W), .HOLD_CYC(HOLD_CYC)
) u_chk (
  .clk(clk), .lsclk(lsclk), .por_n(por_n), .rst_n(rst_n),
  .wr_en(wr_en), .wr_addr(wr_addr), .unlocked(unlocked),
  .pre_busy(pre_busy), .rld_busy(rld_busy), .pre_sh(pre_sh), .rld_sh(rld_sh),
  .run_q(run_q), .kick_ev(kick_ev), .dbg_freeze(dbg_freeze),
  .cnt_q(cnt_q), .pc_q(pc_q), .wdg_rst_req(wdg_rst_req), .cause_flag(cause_flag)
);

// File: tb/sim_indep_watchdog.sv
`timescale 1ns/1ps
module sim_indep_watchdog;
  localparam int HOLD = 4;
  localparam int SLACK = 6;

  logic clk = 0, lsclk = 0, clk_run = 1;
  logic por_n = 0, rst_n = 0, wr_en = 0, dbg_freeze = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic wdg_rst_req, cause_flag;

  int checks = 0, errors = 0;
  int lcnt = 0, kick = 0, nexp = 0, hi_run = 0;
  bit armed = 0, fired = 0;

  always begin #2; if (clk_run) clk = ~clk; end
  always #11 lsclk = ~lsclk;

  indep_watchdog #(.RLD_W(8), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .lsclk(lsclk),
    .dbg_freeze(dbg_freeze), .wdg_rst_req(wdg_rst_req), .cause_flag(cause_flag));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model of expiry time, stepped on every watchdog clock
  always @(posedge lsclk) lcnt++;
  always @(negedge lsclk) begin
    if (armed && dbg_freeze) kick++;
    if (armed) begin
      if (wdg_rst_req) begin
        chk(lcnt - kick >= nexp && lcnt - kick <= nexp + SLACK, "R3",
            "expiry cycle", lcnt - kick, nexp);
        armed = 0; fired = 1;
      end else if (lcnt - kick > nexp + SLACK) begin
        chk(0, "R3", "no expiry by window end", lcnt - kick, nexp);
        armed = 0;
      end
    end else if (!fired && wdg_rst_req && rst_n && por_n) begin
      chk(0, "R4", "unexpected reset request", 1, 0);
    end
    if (wdg_rst_req) hi_run++;
    else if (hi_run != 0) begin
      chk(hi_run == HOLD, "R10", "request length", hi_run, HOLD);
      hi_run = 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask

  task automatic lwait(input int n);
    repeat (n) @(negedge lsclk);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      rd(2'd3, s);
      if (s[1:0] == 2'b00) break;
    end
    chk(s[1:0] == 2'b00, "R8", "busy bits clear", s[1:0], 0);
  endtask

  task automatic arm(input int n);
    kick = lcnt; nexp = n; fired = 0; armed = 1;
  endtask

  task automatic wait_fire(input string req);
    for (int i = 0; i < 4000 && armed; i++) @(negedge lsclk);
    chk(fired, req, "expiry observed", fired, 1);
    lwait(HOLD + 2);
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 0;
    repeat (4) @(negedge clk); rst_n = 1;
    lwait(3);
  endtask

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    por_n = 1; rst_n = 1;
    repeat (3) @(negedge clk);

    rd(2'd1, v); chk(v == 0, "R1", "divider reset", v, 0);
    rd(2'd2, v); chk(v == 255, "R1", "reload reset", v, 255);
    rd(2'd3, v); chk(v == 0, "R1", "status reset", v, 0);
    chk(!wdg_rst_req && !cause_flag, "R1", "outputs idle", {wdg_rst_req, cause_flag}, 0);

    wr(2'd1, 3); rd(2'd1, v); chk(v == 0, "R6", "locked divider write", v, 0);
    wr(2'd0, 32'h5555); wr(2'd1, 1);
    rd(2'd3, v); chk(v[0] == 1, "R8", "divider busy set", v[0], 1);
    wr(2'd2, 7); rd(2'd2, v); chk(v == 255, "R8", "reload write while busy", v, 255);
    wait_idle();
    rd(2'd1, v); chk(v == 1, "R7", "divider code 1", v, 1);
    wr(2'd2, 20); wait_idle();
    rd(2'd2, v); chk(v == 20, "R6", "unlocked reload write", v, 20);
    wr(2'd0, 32'h1234); wr(2'd2, 99);
    rd(2'd2, v); chk(v == 20, "R6", "relocked reload write", v, 20);

    wr(2'd0, 32'hAAAA); lwait(40);
    rd(2'd3, v); chk(v[2] == 0, "R4", "reload key leaves idle", v[2], 0);

    wr(2'd0, 32'hCCCC); arm(20 * 8);
    lwait(20); rd(2'd3, v); chk(v[2] == 1, "R2", "running after start", v[2], 1);
    wr(2'd0, 32'h0); wr(2'd0, 32'hFFFF_FFFF); wr(2'd3, 32'h7);
    lwait(70);
    rd(2'd3, v); chk(v[2] == 1, "R5", "still running after writes", v[2], 1);
    chk(!wdg_rst_req, "R4", "no request before refresh", wdg_rst_req, 0);
    wr(2'd0, 32'hAAAA); arm(20 * 8);
    wait_fire("R4");
    chk(cause_flag, "R11", "flag set on expiry", cause_flag, 1);

    sys_reset();
    chk(cause_flag, "R11", "flag survives rst_n", cause_flag, 1);
    rd(2'd3, v); chk(v[3:2] == 2'b10, "R5", "idle after rst_n, flag read", v[3:2], 2);
    wr(2'd3, 32'h8); lwait(8);
    chk(!cause_flag, "R11", "flag cleared by write", cause_flag, 0);

    wr(2'd0, 32'hCCCC); arm(255 * 4);
    lwait(30); dbg_freeze = 1; lwait(200); dbg_freeze = 0;
    wait_fire("R9");

    sys_reset();
    wr(2'd0, 32'hCCCC); arm(255 * 4);
    @(negedge clk); clk_run = 0;
    wait_fire("R12");
    clk_run = 1;
    chk(cause_flag, "R12", "flag with bus clock stopped", cause_flag, 1);

    sys_reset();
    wr(2'd0, 32'h5555); wr(2'd1, 7); wait_idle();
    wr(2'd2, 2); wait_idle();
    wr(2'd0, 32'hCCCC); arm(2 * 256);
    wait_fire("R7");

    @(negedge clk); por_n = 0; rst_n = 0;
    repeat (2) @(negedge clk); por_n = 1; rst_n = 1;
    lwait(2);
    chk(!cause_flag, "R11", "flag cleared by por_n", cause_flag, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    checks++; errors++;
    $display("FAIL watchdog timeout: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule